// File: doc/BRIEF.md
# Set/Clear Aliased Status Register

This block holds one 64-bit control and status word behind a simple register-access port. The port carries a word address, a read strobe, a write strobe, write data and read data. The byte address divided by eight gives the word address, and only full 64-bit accesses exist. Three neighbouring word addresses lead to the same storage:

- the first address replaces the word with the write data;
- the second keeps only the bits that are set in both the current word and the write data;
- the third adds the bits that are set in the write data.

Only the top 16 bits hold state. Every write clears the lower 48 bits. The most significant stored bit drives a level interrupt line toward an interrupt controller. Any other address is treated as unimplemented. Such an access leaves the word untouched, reads back zero and raises a one-cycle error pulse.

Software uses the two merge addresses to acknowledge or raise individual flags without a read-modify-write sequence. The interrupt line then follows the top flag directly.

Top module: `alias_status_reg`

## Requirements
- R1: A write (wr_en high) at word address 0x4020 stores the write data, with bits 47..0 forced to zero, on that clock edge.
- R2: A write at word address 0x4021 stores (current value AND write data) with bits 47..0 forced to zero.
- R3: A write at word address 0x4022 stores (current value OR write data) with bits 47..0 forced to zero.
- R4: Bits 47..0 of the stored word are zero at all times, so a read at 0x4020 returns zero in those bits.
- R5: irq equals bit 63 of the stored word and changes on the same edge as the write that updates the word.
- R6: A write at any address other than 0x4020, 0x4021 and 0x4022 leaves the stored word and irq unchanged and sets err high for the following cycle only.
- R7: A read (rd_en high) at 0x4020 returns the stored word on rd_data one cycle later. A read at any other address, including 0x4021 and 0x4022, returns zero one cycle later and sets err for that cycle.
- R8: A synchronous active-high reset clears the stored word, irq and err.
- R9: A read and a write at 0x4020 in the same cycle return the value held before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 16 | Word address (byte address shifted right by 3) |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, valid the cycle after rd_en |
| err | output | 1 | One-cycle pulse after an access to an unimplemented address |
| irq | output | 1 | Level interrupt, equal to stored bit 63 |

## Verification
The bench builds the block with its default parameters:

- a 64-bit word;
- 16 retained bits;
- a 16-bit word address;
- a base offset of 0x4020.

These defaults place the three aliases at 0x4020 through 0x4022. The bench can therefore probe the neighbours 0x401F and 0x4023 on either side, as well as a far address.

With 16 retained bits, an all-ones direct write shows the 48-bit clear. AND and OR writes that touch bit 63 toggle the interrupt in both directions. A read combined with a write in one cycle exposes the value held before that write.

// File: rtl/alias_reg_pkg.sv
package alias_reg_pkg;

    // Which alias (if any) an access lands on
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_DIRECT = 2'd1,
        ACC_CLEAR  = 2'd2,
        ACC_SET    = 2'd3
    } acc_kind_e;

    // Decoded access, one per cycle
    typedef struct packed {
        acc_kind_e kind;
        logic      wr_go;   // write to one of the aliases
        logic      rd_go;   // read of the direct alias
        logic      bad;     // access to an unimplemented location
    } acc_dec_t;

endpackage

// File: rtl/alias_decode.sv
module alias_decode
    import alias_reg_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_OFF = 16'h4020
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    output acc_dec_t          dec
);
    localparam logic [ADDR_W-1:0] OFF_CLR = BASE_OFF + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_SET = BASE_OFF + ADDR_W'(2);

    acc_kind_e kind;

    always_comb begin
        if (addr == BASE_OFF)     kind = ACC_DIRECT;
        else if (addr == OFF_CLR) kind = ACC_CLEAR;
        else if (addr == OFF_SET) kind = ACC_SET;
        else                      kind = ACC_NONE;
    end

    always_comb begin
        dec.kind  = kind;
        dec.wr_go = wr_en && (kind != ACC_NONE);
        dec.rd_go = rd_en && (kind == ACC_DIRECT);
        dec.bad   = (wr_en && (kind == ACC_NONE)) ||
                    (rd_en && (kind != ACC_DIRECT));
    end
endmodule

// File: rtl/alias_merge.sv
module alias_merge
    import alias_reg_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int KEEP_W = 16
) (
    input  acc_kind_e         kind,
    input  logic [DATA_W-1:0] cur,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] nxt
);
    localparam int DROP_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {DROP_W{1'b0}}};

    logic [DATA_W-1:0] raw;

    always_comb begin
        unique case (kind)
            ACC_DIRECT: raw = wdata;
            ACC_CLEAR:  raw = cur & wdata;
            ACC_SET:    raw = cur | wdata;
            default:    raw = cur;
        endcase
        nxt = raw & KEEP_MASK;
    end
endmodule

// File: rtl/alias_store.sv
module alias_store #(
    parameter int DATA_W = 64,
    parameter int KEEP_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              apply,
    input  logic [DATA_W-1:0] nxt,
    output logic [DATA_W-1:0] q,
    output logic              irq
);
    localparam int DROP_W = DATA_W - KEEP_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            q   <= '0;
            irq <= 1'b0;
        end else if (apply) begin
            q   <= nxt;
            irq <= nxt[DATA_W-1];
        end
    end

    // R4: the dropped field never holds state
    assert_low_bits_zero_R4: assert property (@(posedge clk) disable iff (rst)
        q[DROP_W-1:0] == '0);

    // R5: interrupt line mirrors the top stored bit
    assert_irq_mirrors_top_R5: assert property (@(posedge clk) disable iff (rst)
        irq == q[DATA_W-1]);
endmodule

// File: rtl/alias_status_reg.sv
module alias_status_reg
    import alias_reg_pkg::*;
#(
    parameter int                DATA_W   = 64,
    parameter int                KEEP_W   = 16,
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] BASE_OFF = 16'h4020
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              err,
    output logic              irq
);
    localparam int DROP_W = DATA_W - KEEP_W;
    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_W{1'b1}}, {DROP_W{1'b0}}};
    localparam logic [ADDR_W-1:0] OFF_CLR = BASE_OFF + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_SET = BASE_OFF + ADDR_W'(2);

    acc_dec_t          dec;
    logic [DATA_W-1:0] stored;
    logic [DATA_W-1:0] nxt;

    alias_decode #(.ADDR_W(ADDR_W), .BASE_OFF(BASE_OFF)) u_decode (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .dec   (dec)
    );

    alias_merge #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_merge (
        .kind  (dec.kind),
        .cur   (stored),
        .wdata (wr_data),
        .nxt   (nxt)
    );

    alias_store #(.DATA_W(DATA_W), .KEEP_W(KEEP_W)) u_store (
        .clk   (clk),
        .rst   (rst),
        .apply (dec.wr_go),
        .nxt   (nxt),
        .q     (stored),
        .irq   (irq)
    );

    // Read path and error pulse
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            err     <= 1'b0;
        end else begin
            err <= dec.bad;
            if (rd_en) rd_data <= dec.rd_go ? stored : '0;
        end
    end

    // R1: direct alias replaces the word
    assert_direct_write_R1: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE_OFF) |=> stored == ($past(wr_data) & KEEP_MASK));

    // R2: clear alias ANDs into the word
    assert_clear_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_CLR) |=>
            stored == (($past(stored) & $past(wr_data)) & KEEP_MASK));

    // R3: set alias ORs into the word
    assert_set_write_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == OFF_SET) |=>
            stored == (($past(stored) | $past(wr_data)) & KEEP_MASK));

    // R6: unimplemented write leaves state alone and flags an error
    assert_bad_write_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr != BASE_OFF && addr != OFF_CLR && addr != OFF_SET) |=>
            ($stable(stored) && $stable(irq) && err));

    // R7: read away from the direct alias returns zero with an error
    assert_bad_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr != BASE_OFF) |=> (rd_data == '0 && err));

    // R9: combined read/write returns the earlier value
    assert_read_before_write_R9: assert property (@(posedge clk) disable iff (rst)
        (rd_en && wr_en && addr == BASE_OFF) |=> rd_data == $past(stored));
endmodule

// File: tb/tb_alias_status_reg.sv
module tb_alias_status_reg;
    localparam int DATA_W = 64;
    localparam int ADDR_W = 16;
    localparam logic [63:0] MASK = 64'hFFFF_0000_0000_0000;

    typedef struct {
        int          due;
        logic        chk_data;
        logic [63:0] exp_data;
        logic        exp_err;
        logic        exp_irq;
        string       req;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              rd_en = 1'b0;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              err;
    logic              irq;

    int          checks = 0;
    int          errors = 0;
    int          cyc = 0;
    logic [63:0] model = '0;
    item_t       q[$];

    always #4 clk = ~clk;   // 125 MHz
    always @(posedge clk) cyc <= cyc + 1;

    alias_status_reg dut (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .err(err), .irq(irq)
    );

    // Monitor: pops items once their result cycle has arrived
    always @(negedge clk) begin
        if (q.size() > 0 && q[0].due <= cyc) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (it.chk_data && rd_data !== it.exp_data) begin
                errors++;
                $display("FAIL %s rd_data got %h exp %h", it.req, rd_data, it.exp_data);
            end
            if (err !== it.exp_err || irq !== it.exp_irq) begin
                errors++;
                $display("FAIL %s err/irq got %b/%b exp %b/%b",
                         it.req, err, irq, it.exp_err, it.exp_irq);
            end
        end
    end

    // Driver: one access per cycle, expectation pushed to the scoreboard
    task automatic op(input logic r, input logic w, input logic [15:0] a,
                      input logic [63:0] d, input string req);
        item_t it;
        logic  hit_w, hit_r, bad;
        @(negedge clk);
        rd_en = r; wr_en = w; addr = a; wr_data = d;
        hit_r = (a == 16'h4020);
        hit_w = (a == 16'h4020) || (a == 16'h4021) || (a == 16'h4022);
        bad   = (w && !hit_w) || (r && !hit_r);
        it.due      = cyc + 1;
        it.chk_data = r;
        it.exp_data = hit_r ? model : 64'h0;
        it.exp_err  = bad;
        if (w) begin
            if (a == 16'h4020)      model = d & MASK;
            else if (a == 16'h4021) model = (model & d) & MASK;
            else if (a == 16'h4022) model = (model | d) & MASK;
        end
        it.exp_irq = model[63];
        it.req     = req;
        q.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic drain();
        while (q.size() > 0) idle();
        idle();
    endtask

    task automatic do_reset();
        drain();
        rst = 1'b1;
        repeat (2) idle();
        rst = 1'b0;
        model = '0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        op(1, 0, 16'h4020, 0, "R8 reset state");
        op(0, 1, 16'h4020, 64'hFFFF_FFFF_FFFF_FFFF, "R1 direct write all ones / R5 irq rise");
        op(1, 0, 16'h4020, 0, "R4 low bits cleared");
        op(0, 1, 16'h4021, 64'h7FFF_FFFF_FFFF_FFFF, "R2 clear bit 63 / R5 irq fall");
        op(1, 0, 16'h4020, 0, "R2 readback");
        op(0, 1, 16'h4022, 64'h8000_0000_0000_1234, "R3 set bit 63 / R5 irq rise");
        op(1, 0, 16'h4020, 0, "R3 readback");
        op(0, 1, 16'h4021, 64'h00F0_FFFF_FFFF_FFFF, "R2 clear pattern");
        op(0, 1, 16'h4022, 64'h0100_0000_0000_0001, "R3 set pattern back to back");
        op(1, 0, 16'h4020, 0, "R3 readback after chain");
        op(0, 1, 16'h401F, 64'hFFFF_FFFF_FFFF_FFFF, "R6 write below aliases");
        op(0, 1, 16'h4023, 64'hFFFF_FFFF_FFFF_FFFF, "R6 write above aliases");
        op(0, 1, 16'h0000, 64'h0, "R6 write far address");
        op(1, 0, 16'h4020, 0, "R6 state unchanged");
        op(1, 0, 16'h4021, 0, "R7 read clear alias");
        op(1, 0, 16'h4022, 0, "R7 read set alias");
        op(1, 0, 16'hFFFF, 0, "R7 read far address");
        op(1, 1, 16'h4020, 64'hABCD_1234_5678_9ABC, "R9 read with write");
        op(1, 0, 16'h4020, 0, "R9 new value visible");
        op(0, 1, 16'h4022, 64'h8000_0000_0000_0000, "R5 set top before reset");
        do_reset();
        op(1, 0, 16'h4020, 0, "R8 reset clears word and irq");
        drain();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule